// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides, for a small 8-bit CPU core, whether an interrupt is taken at the current instruction boundary and which vector the core should use. It looks at a vector of level-held maskable requests, a software trap strobe and the global mask bit. One clock after a qualifying boundary it issues a take strobe, the vector index and a one-hot acknowledge to the winning source. It also tells the core to set the mask bit. The core then pushes its program counter, index, accumulator and condition codes and loads the vector. Register stacking and instruction fetch stay in the core.

The lowest-numbered maskable request has the highest priority. The software trap has its own vector index, equal to the number of maskable sources. The trap ignores the mask bit and beats any maskable request at the same boundary. A return-from-interrupt strobe tells the core to clear the mask bit.

The block also produces a wake signal for the two low-power modes. In wait mode any request ends the sleep, even a request that the mask bit is holding back. In halt mode only the sources selected by the `HALT_CAP` parameter can wake the core.

Top module: `irq_entry_ctrl`

## Requirements
- R1: `take_o` is high for exactly the one cycle after a clock edge at which `instr_end_i` was high and an eligible source existed. It is never high after an edge where `instr_end_i` was low.
- R2: A maskable request is eligible only while `mask_i` is 0. A request that is still held when the mask later reads 0 at a boundary is then taken.
- R3: In the cycle of `take_o`, `mask_set_o` is 1. Otherwise `mask_set_o` is 0.
- R4: `mask_clr_o` is 1 in the cycle after an edge with `iret_i` high and no entry. When an entry happens at the same edge, `mask_clr_o` stays 0.
- R5: Among eligible maskable requests, the lowest index n wins. `vec_o` equals n and `ack_o` has only bit n set, in the same cycle as `take_o`.
- R6: A trap at a boundary is taken whatever `mask_i` holds, and it beats maskable requests. In that case `vec_o` equals `NUM_SRC` and `ack_o` is 0.
- R7: `wake_o` is 1 in the cycle after an edge where `in_wait_i` was high and any request or trap was present, whatever the mask bit holds.
- R8: In halt mode, `wake_o` is 1 only if a request from a source whose `HALT_CAP` bit is 1 was present. Other requests in halt mode leave `wake_o` at 0.
- R9: While reset is asserted, and in every cycle without an entry, `vec_o` and `ack_o` are 0. During reset all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Level maskable requests, held until acknowledged |
| trap_i | input | 1 | Software trap instruction at this boundary |
| mask_i | input | 1 | Current global mask bit from the core |
| instr_end_i | input | 1 | Current instruction completes this cycle |
| iret_i | input | 1 | Return-from-interrupt completes this cycle |
| in_wait_i | input | 1 | Core is in wait mode |
| in_halt_i | input | 1 | Core is in halt mode |
| take_o | output | 1 | Enter interrupt: stack registers and load vector |
| vec_o | output | VEC_W | Selected vector index (trap = NUM_SRC) |
| mask_set_o | output | 1 | Set the global mask bit |
| mask_clr_o | output | 1 | Clear the global mask bit |
| ack_o | output | NUM_SRC | One-hot acknowledge to the winning source |
| wake_o | output | 1 | Leave the current low-power mode |

## Verification
The assertions assume that `in_wait_i` and `in_halt_i` are never high together. They also assume that a trap or return strobe only comes with a completing instruction, or at least does not come while the core sleeps. The random stimulus picks one power mode per cycle (none, wait or halt). It raises `trap_i` and `iret_i` only rarely and draws the request vector and the mask bit freely. Directed cases then cover the mask holding a request back and releasing it later, a trap meeting a masked request, a return meeting an entry, and halt with sources that cannot wake it.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   // Which kind of source won the current boundary
   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_MASKABLE = 2'd1,
      PICK_TRAP = 2'd2
   } pick_kind_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 8,
   parameter int VW = 4,
   parameter int IMPL = 0   // 0: priority loop, 1: lowest-bit isolation
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [N-1:0]  grant,
   output logic [VW-1:0] idx
);
   assign any = |req;

   generate
      if (IMPL == 0) begin : g_loop
         always_comb begin
            grant = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) grant = N'(1) << i;
            end
         end
      end else begin : g_iso
         assign grant = req & (~req + N'(1));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | VW'(i);
      end
   end
endmodule

// File: rtl/irq_wake_eval.sv
module irq_wake_eval #(
   parameter int N = 8,
   parameter logic [N-1:0] HALT_CAP = '1
) (
   input  logic [N-1:0] req,
   input  logic         trap,
   input  logic         in_wait,
   input  logic         in_halt,
   output logic         wake
);
   logic wait_ev, halt_ev;
   // wait ends on any request; the mask bit plays no part
   assign wait_ev = (|req) | trap;
   // halt ends only on sources allowed to run the oscillator back up
   assign halt_ev = |(req & HALT_CAP);
   assign wake = (in_wait & wait_ev) | (in_halt & halt_ev);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
   parameter int NUM_SRC = 8,
   parameter logic [NUM_SRC-1:0] HALT_CAP = NUM_SRC'(8'h0F),
   parameter int PRIO_IMPL = 0,
   localparam int VEC_W = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               trap_i,
   input  logic               mask_i,
   input  logic               instr_end_i,
   input  logic               iret_i,
   input  logic               in_wait_i,
   input  logic               in_halt_i,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               mask_set_o,
   output logic               mask_clr_o,
   output logic [NUM_SRC-1:0] ack_o,
   output logic               wake_o
);
   import irq_entry_pkg::*;

   localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(NUM_SRC);

   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
      $error("irq_entry_ctrl: NUM_SRC out of range");
   end
   if (PRIO_IMPL != 0 && PRIO_IMPL != 1) begin : g_bad_impl
      $error("irq_entry_ctrl: PRIO_IMPL must be 0 or 1");
   end

   logic               any_req;
   logic [NUM_SRC-1:0] grant;
   logic [VEC_W-1:0]   grant_idx;
   logic               wake_c;
   pick_kind_e         pick;

   irq_prio_pick #(.N(NUM_SRC), .VW(VEC_W), .IMPL(PRIO_IMPL)) u_pick (
      .req(req_i), .any(any_req), .grant(grant), .idx(grant_idx));

   irq_wake_eval #(.N(NUM_SRC), .HALT_CAP(HALT_CAP)) u_wake (
      .req(req_i), .trap(trap_i), .in_wait(in_wait_i),
      .in_halt(in_halt_i), .wake(wake_c));

   // Boundary decision: trap first, then maskable if the mask is clear
   always_comb begin
      pick = PICK_NONE;
      if (instr_end_i) begin
         if (trap_i) pick = PICK_TRAP;
         else if (any_req && !mask_i) pick = PICK_MASKABLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o     <= 1'b0;
         vec_o      <= '0;
         mask_set_o <= 1'b0;
         mask_clr_o <= 1'b0;
         ack_o      <= '0;
         wake_o     <= 1'b0;
      end else begin
         take_o     <= (pick != PICK_NONE);
         mask_set_o <= (pick != PICK_NONE);
         mask_clr_o <= iret_i && (pick == PICK_NONE);
         wake_o     <= wake_c;
         case (pick)
            PICK_TRAP: begin
               vec_o <= TRAP_VEC;
               ack_o <= '0;
            end
            PICK_MASKABLE: begin
               vec_o <= grant_idx;
               ack_o <= grant;
            end
            default: begin
               vec_o <= '0;
               ack_o <= '0;
            end
         endcase
      end
   end

   // R2: a masked boundary without trap enters nothing
   a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_end_i && !trap_i && mask_i) |=> !take_o);
   // R1: entry only at an instruction boundary
   a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_end_i |=> !take_o);
   // R6: trap taken regardless of mask, with its own vector and mask set
   a_r6_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_end_i && trap_i) |=> (take_o && mask_set_o && vec_o == TRAP_VEC && ack_o == '0));
   // R4: a return with no entry clears the mask
   a_r4_iret_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_i && !instr_end_i) |=> mask_clr_o);
   // R5: at most one source acknowledged, and only with an entry
   a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o) && ((ack_o != '0) -> take_o));
   // R8: halt is not ended by sources lacking halt capability
   a_r8_halt_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (in_halt_i && !in_wait_i && ((req_i & HALT_CAP) == '0)) |=> !wake_o);
   // R7: wait ends on any request even with the mask set
   a_r7_wait_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait_i && (req_i != '0)) |=> wake_o);
endmodule

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;
   localparam int N = 8;
   localparam logic [N-1:0] CAP = 8'h0F;
   localparam int VW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic trap = 0, mask = 0, ie = 0, iret = 0, w = 0, h = 0;
   logic take, mset, mclr, wake;
   logic [VW-1:0] vec;
   logic [N-1:0] ack;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_entry_ctrl #(.NUM_SRC(N), .HALT_CAP(CAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .trap_i(trap), .mask_i(mask),
      .instr_end_i(ie), .iret_i(iret), .in_wait_i(w), .in_halt_i(h),
      .take_o(take), .vec_o(vec), .mask_set_o(mset), .mask_clr_o(mclr),
      .ack_o(ack), .wake_o(wake));

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowest(logic [N-1:0] r);
      for (int i = 0; i < N; i++) if (r[i]) return i;
      return -1;
   endfunction

   // Drive one cycle, then check the registered reaction
   task automatic step(logic [N-1:0] r, logic t, logic m, logic e,
                       logic ir, logic ww, logic hh);
      bit exp_take, exp_wake;
      int exp_vec;
      logic [N-1:0] exp_ack;
      req = r; trap = t; mask = m; ie = e; iret = ir; w = ww; h = hh;
      exp_take = e && (t || (r != '0 && !m));
      exp_vec = 0; exp_ack = '0;
      if (exp_take && t) exp_vec = N;
      else if (exp_take) begin
         exp_vec = lowest(r);
         exp_ack = N'(1) << exp_vec;
      end
      exp_wake = (ww && (r != '0 || t)) || (hh && (r & CAP) != '0);
      @(negedge clk);
      chk("R1 take", take, exp_take);
      chk("R3 mask_set", mset, exp_take);
      chk("R4 mask_clr", mclr, ir && !exp_take);
      chk("R5/R6 vec", vec, exp_vec);
      chk("R5/R6/R9 ack", ack, exp_ack);
      chk("R7/R8 wake", wake, exp_wake);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      req = 8'hFF; trap = 1; ie = 1; w = 1;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 take", take, 0); chk("R9 vec", vec, 0); chk("R9 ack", ack, 0);
      chk("R9 wake", wake, 0); chk("R9 mset", mset, 0); chk("R9 mclr", mclr, 0);
      rst_n = 1;
      // R2: held request blocked by the mask, then taken when it clears
      step(8'h20, 0, 1, 1, 0, 0, 0);
      chk("R2 held", take, 0);
      step(8'h20, 0, 0, 0, 0, 0, 0);
      step(8'h20, 0, 0, 1, 0, 0, 0);
      chk("R2 released vec", vec, 5);
      // R5: priority among many
      step(8'hA4, 0, 0, 1, 0, 0, 0);
      chk("R5 lowest wins", ack, 8'h04);
      // R6: trap with mask set and requests pending
      step(8'h01, 1, 1, 1, 0, 0, 0);
      chk("R6 trap vec", vec, N);
      step(8'h01, 1, 0, 1, 0, 0, 0);
      chk("R6 trap beats req0", ack, 0);
      // R4: return coinciding with entry, then alone
      step(8'h02, 0, 0, 1, 1, 0, 0);
      chk("R4 collide", mclr, 0);
      step(8'h00, 0, 1, 1, 1, 0, 0);
      chk("R4 alone", mclr, 1);
      // R8: halt with non-capable sources only, then capable one
      step(8'hF0, 0, 1, 0, 0, 0, 1);
      chk("R8 no wake", wake, 0);
      step(8'h08, 0, 1, 0, 0, 0, 1);
      chk("R8 wake", wake, 1);
      // R7: wait ends on masked request
      step(8'h80, 0, 1, 0, 0, 1, 0);
      chk("R7 masked wake", wake, 1);
      // random
      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] r;
         int md;
         logic ww, hh, ev, t, ir;
         r = ($urandom % 3 == 0) ? '0 : N'($urandom);
         if ($urandom % 2 == 0) r = r & N'($urandom);
         md = $urandom % 3;
         ww = (md == 1); hh = (md == 2);
         ev = !hh && ($urandom % 2 == 0);
         t = ev && ($urandom % 8 == 0);
         ir = !hh && ($urandom % 8 == 0);
         step(r, t, 1'($urandom), ev, ir, ww, hh);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule